// File: doc/BRIEF.md
# TDM Slot Engine for a Serial Audio Port

This block adds time-division-multiplexed operation to a serial audio port. A frame begins on a frame-start strobe and is divided into one to eight equal slots. Each slot is one to thirty-two bit clocks wide. Two independent slot masks decide which slots carry transmit data and which slots are captured into the receive path. Transmit words come from a small FIFO and are shifted out MSB first. Received words are assembled bit by bit and pushed into a second FIFO, right-justified.

The bit clock arrives as a one-cycle enable `bit_en` in the system clock domain, and the frame strobe `frame_sync` is qualified by it. Clock generation and frame-sync shaping happen elsewhere. Threshold comparators on both FIFOs raise service requests for a DMA engine or a CPU, and each comparator has its own enable. Three sticky error flags (receive overrun, transmit underrun, slot cut short by a frame start) are cleared by writing ones. A transmit-enable output lets the pad float TXD in slots the port does not own.

Top module: `tdm_slot_engine`

## Requirements
- R1: A frame starts on a `bit_en` cycle with `frame_sync` high, provided the engine is running and the configuration is valid. It holds `cfg_slots_m1`+1 slots of equal width, and after the last bit of the last slot the engine waits for the next frame start.
- R2: The slot width is `cfg_dsize`+1, plus 16 when `cfg_dsize_ext` is 1. Each transmitted word goes out MSB first from its low width bits, and `txd` takes the value for a bit on the clock edge of that bit's `bit_en` cycle.
- R3: Network mode is in force when `cfg_net_en` is 1 or `cfg_slots_m1` is nonzero. In network mode, bit n of `cfg_tx_mask` / `cfg_rx_mask` enables transmit / receive in slot n. Outside network mode, slot 0 transmits and receives whatever the masks hold.
- R4: With `cfg_run` high, network mode in force and `cfg_tx_mask` zero, `cfg_err` goes to 1 one clock later, and no frame starts: no FIFO word is moved and TXD stays in its idle state.
- R5: With `cfg_tri_en` = 1, `txd_oe` is 0 in slots that do not transmit and outside frames. With `cfg_tri_en` = 0, `txd_oe` is 1 there and `txd` is 0.
- R6: In receive-enabled slots, `rxd` is sampled on each `bit_en` cycle. At the slot's last bit the word is pushed into the receive FIFO, right-justified with zeros above the width. `rx_data` shows the oldest word while `rx_empty` is 0.
- R7: `rx_req` is 1 when `cfg_rx_req_en` is set and the receive FIFO holds at least 8 words. `tx_req` is 1 when `cfg_tx_req_en` is set and the transmit FIFO holds 7 words or fewer. Both are registered.
- R8: Each FIFO holds 16 words. A receive push into a full FIFO drops the word and sets overrun flag `sts_flags[0]`.
- R9: A transmit-enabled slot that starts with an empty transmit FIFO sends zeros and sets underrun flag `sts_flags[1]`.
- R10: A frame start that arrives while a slot is part-way through (bit index not zero) sets `sts_flags[2]`. The partial receive word is discarded and the new frame begins at slot 0, bit 0.
- R11: The flags are sticky. A cycle with `sts_wr` high clears each flag whose `sts_clr` bit is 1, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle bit clock enable |
| frame_sync | input | 1 | Frame start, qualified by bit_en |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Drive enable for the TXD pad |
| cfg_run | input | 1 | Engine run enable |
| cfg_net_en | input | 1 | Force network mode |
| cfg_slots_m1 | input | 3 | Slots per frame minus one |
| cfg_dsize | input | 4 | Slot width minus one (low part) |
| cfg_dsize_ext | input | 1 | Adds 16 to the slot width |
| cfg_tx_mask | input | 8 | Transmit slot enables |
| cfg_rx_mask | input | 8 | Receive slot enables |
| cfg_tri_en | input | 1 | Float TXD in non-transmit slots |
| cfg_tx_req_en | input | 1 | Transmit request enable |
| cfg_rx_req_en | input | 1 | Receive request enable |
| tx_push | input | 1 | Write a word into the transmit FIFO |
| tx_data | input | 32 | Transmit word |
| rx_pop | input | 1 | Remove the oldest receive word |
| rx_data | output | 32 | Oldest receive word |
| rx_empty | output | 1 | Receive FIFO is empty |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| cfg_err | output | 1 | Network mode with no transmit slot |
| sts_wr | input | 1 | Write strobe for flag clearing |
| sts_clr | input | 3 | Ones clear the matching flags |
| sts_flags | output | 3 | Sticky flags: overrun, underrun, bit-count |

## Verification
The bench builds the block with its defaults: eight slots, 32-bit words, 16-entry FIFOs and request thresholds of 7 and 8. With these values a random configuration can reach the full range of slot counts and widths. That range includes one-bit slots, where the first and last bit coincide, and 32-bit slots with the width extension set. Two eight-slot frames of receive traffic fill the receive FIFO exactly, so the third frame drives it into overrun and the request thresholds are crossed on both sides. A reference model in the bench predicts every transmitted bit, drive enable, received word and flag.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int FLG_ROR = 0;
  localparam int FLG_TUR = 1;
  localparam int FLG_BCE = 2;
  localparam int NUM_FLG = 3;

  // slot width from the data size fields
  function automatic logic [5:0] slot_width(input logic [3:0] dsize, input logic ext);
    return 6'(dsize) + 6'd1 + (ext ? 6'd16 : 6'd0);
  endfunction
endpackage

// File: rtl/tdm_fifo.sv
`timescale 1ns/1ps
module tdm_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, empty, do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: occupancy never passes the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R8: an empty FIFO with no push stays empty
  a_r8_empty_holds: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> (count == '0));
endmodule

// File: rtl/tdm_slot_seq.sv
`timescale 1ns/1ps
module tdm_slot_seq #(
  parameter int MAX_SLOTS = 8,
  parameter int DATA_W    = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int WID_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic              enable,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [WID_W-1:0]  width,
  output logic              step,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BIT_W-1:0]  cur_bit,
  output logic              first_bit,
  output logic              last_bit,
  output logic              bce,
  output logic              active
);
  logic              act_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              start, last_slot;

  assign start     = bit_en && frame_sync && enable;
  assign bce       = start && act_q && (bit_q != '0);
  assign cur_slot  = start ? '0 : slot_q;
  assign cur_bit   = start ? '0 : bit_q;
  assign step      = bit_en && enable && (start || act_q);
  assign first_bit = (cur_bit == '0);
  assign last_bit  = ((WID_W'(cur_bit) + WID_W'(1)) == width);
  assign last_slot = (cur_slot == slots_m1);
  assign active    = act_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      act_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else if (step) begin
      if (last_bit) begin
        bit_q <= '0;
        if (last_slot) begin
          act_q  <= 1'b0;
          slot_q <= '0;
        end else begin
          act_q  <= 1'b1;
          slot_q <= cur_slot + 1'b1;
        end
      end else begin
        act_q  <= 1'b1;
        slot_q <= cur_slot;
        bit_q  <= cur_bit + 1'b1;
      end
    end
  end

  // R1: a running frame never indexes a slot past the configured count
  a_r1_slot_in_range: assert property (@(posedge clk) disable iff (rst || !enable)
    act_q |-> (slot_q <= slots_m1));
  // R10: a frame start cutting a slot short resumes at bit 1 or slot end
  a_r10_restart: assert property (@(posedge clk) disable iff (rst || !enable)
    (bce && (width > WID_W'(1))) |=> (act_q && slot_q == '0 && bit_q == BIT_W'(1)));
endmodule

// File: rtl/tdm_sticky_flags.sv
`timescale 1ns/1ps
module tdm_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R11: a set event is always visible on the next cycle
    a_r11_set_sticks: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    // R11: without a clearing write a flag never falls
    a_r11_no_spurious_clear: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(clr_we && clr[i])) |=> flags[i]);
  end
endmodule

// File: rtl/tdm_slot_engine.sv
`timescale 1ns/1ps
module tdm_slot_engine #(
  parameter int MAX_SLOTS  = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int TX_THRESH  = 7,
  parameter int RX_THRESH  = 8,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int WID_W  = $clog2(DATA_W + 1),
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 frame_sync,
  input  logic                 rxd,
  output logic                 txd,
  output logic                 txd_oe,
  input  logic                 cfg_run,
  input  logic                 cfg_net_en,
  input  logic [SLOT_W-1:0]    cfg_slots_m1,
  input  logic [3:0]           cfg_dsize,
  input  logic                 cfg_dsize_ext,
  input  logic [MAX_SLOTS-1:0] cfg_tx_mask,
  input  logic [MAX_SLOTS-1:0] cfg_rx_mask,
  input  logic                 cfg_tri_en,
  input  logic                 cfg_tx_req_en,
  input  logic                 cfg_rx_req_en,
  input  logic                 tx_push,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 rx_pop,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 rx_empty,
  output logic                 tx_req,
  output logic                 rx_req,
  output logic                 cfg_err,
  input  logic                 sts_wr,
  input  logic [2:0]           sts_clr,
  output logic [2:0]           sts_flags
);
  import tdm_pkg::*;

  logic              net_mode, cfg_err_now, enable;
  logic [WID_W-1:0]  width;
  logic              step, first_bit, last_bit, bce, seq_active;
  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_bit, out_idx;
  logic              tx_sel, rx_sel, tx_load, tx_pop, tx_empty, tur_set;
  logic [DATA_W-1:0] tx_head, tx_word_q, tx_word_now;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] rx_next;
  logic              rx_done, rx_full, rx_push, ror_set;
  logic [NUM_FLG-1:0] flag_set;

  // ---------------- configuration decode ----------------
  assign width       = WID_W'(slot_width(cfg_dsize, cfg_dsize_ext));
  assign net_mode    = cfg_net_en || (cfg_slots_m1 != '0);
  assign cfg_err_now = cfg_run && net_mode && (cfg_tx_mask == '0);
  assign enable      = cfg_run && !cfg_err_now;

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_err_now;
  end

  tdm_slot_seq #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .enable(enable), .slots_m1(cfg_slots_m1), .width(width),
    .step(step), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .first_bit(first_bit), .last_bit(last_bit), .bce(bce), .active(seq_active)
  );

  assign tx_sel = net_mode ? cfg_tx_mask[cur_slot] : 1'b1;
  assign rx_sel = net_mode ? cfg_rx_mask[cur_slot] : 1'b1;

  // ---------------- transmit path ----------------
  tdm_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk(clk), .rst(rst), .push(tx_push), .din(tx_data),
    .pop(tx_pop), .dout(tx_head), .count(tx_count)
  );

  assign tx_empty    = (tx_count == '0);
  assign tx_load     = step && first_bit && tx_sel;
  assign tx_pop      = tx_load && !tx_empty;
  assign tur_set     = tx_load && tx_empty;
  assign tx_word_now = first_bit ? (tx_empty ? '0 : tx_head) : tx_word_q;
  assign out_idx     = BIT_W'(width - WID_W'(1)) - cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b0;
      txd_oe    <= 1'b0;
      tx_word_q <= '0;
    end else if (bit_en) begin
      if (step) begin
        if (tx_load) tx_word_q <= tx_word_now;
        txd    <= tx_sel ? tx_word_now[out_idx] : 1'b0;
        txd_oe <= tx_sel || !cfg_tri_en;
      end else begin
        txd    <= 1'b0;
        txd_oe <= !cfg_tri_en;
      end
    end
  end

  // ---------------- receive path ----------------
  assign rx_next = first_bit ? DATA_W'(rxd) : {rx_sh, rxd};
  assign rx_done = step && rx_sel && last_bit;
  assign rx_full = (rx_count == CNT_W'(FIFO_DEPTH));
  assign rx_push = rx_done && !rx_full;
  assign ror_set = rx_done && rx_full;

  always_ff @(posedge clk) begin
    if (rst)                 rx_sh <= '0;
    else if (step && rx_sel) rx_sh <= rx_next[DATA_W-2:0];
  end

  tdm_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_next),
    .pop(rx_pop), .dout(rx_data), .count(rx_count)
  );
  assign rx_empty = (rx_count == '0);

  // ---------------- service requests ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      tx_req <= cfg_tx_req_en && (tx_count <= CNT_W'(TX_THRESH));
      rx_req <= cfg_rx_req_en && (rx_count >= CNT_W'(RX_THRESH));
    end
  end

  // ---------------- sticky status ----------------
  always_comb begin
    flag_set          = '0;
    flag_set[FLG_ROR] = ror_set;
    flag_set[FLG_TUR] = tur_set;
    flag_set[FLG_BCE] = bce;
  end

  tdm_sticky_flags #(.N(NUM_FLG)) i_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr_we(sts_wr),
    .clr(sts_clr), .flags(sts_flags)
  );

  // R4: a bad configuration keeps the slot sequencer idle
  a_r4_err_blocks_frame: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !seq_active);
  // R9: the first bit of an underrun slot goes out as zero
  a_r9_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    tur_set |=> !txd);
  // R7: requests stay low while their enables are off
  a_r7_tx_req_gate: assert property (@(posedge clk) disable iff (rst)
    !cfg_tx_req_en |=> !tx_req);
  a_r7_rx_req_gate: assert property (@(posedge clk) disable iff (rst)
    !cfg_rx_req_en |=> !rx_req);
  // R5: with floating enabled, a bit clock outside any frame releases TXD
  a_r5_idle_float: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !step && cfg_tri_en) |=> !txd_oe);
endmodule

// File: tb/test_tdm_slot_engine.sv
`timescale 1ns/1ps
module test_tdm_slot_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 0, frame_sync = 0, rxd = 0;
  logic        txd, txd_oe;
  logic        c_run = 0, c_net = 0, c_ext = 0, c_tri = 0, c_txre = 0, c_rxre = 0;
  logic [2:0]  c_sm1 = 0;
  logic [3:0]  c_dsize = 0;
  logic [7:0]  c_txm = 0, c_rxm = 0;
  logic        tx_push = 0, rx_pop = 0, sts_wr = 0;
  logic [31:0] tx_data = 0;
  logic [31:0] rx_data;
  logic        rx_empty, tx_req, rx_req, cfg_err;
  logic [2:0]  sts_clr = 0;
  logic [2:0]  sts_flags;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [2:0]  exp_flags = 0;
  bit          pend_mid = 0;

  always #10 clk = ~clk;

  tdm_slot_engine i_tdm_slot_engine (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync), .rxd(rxd),
    .txd(txd), .txd_oe(txd_oe), .cfg_run(c_run), .cfg_net_en(c_net),
    .cfg_slots_m1(c_sm1), .cfg_dsize(c_dsize), .cfg_dsize_ext(c_ext),
    .cfg_tx_mask(c_txm), .cfg_rx_mask(c_rxm), .cfg_tri_en(c_tri),
    .cfg_tx_req_en(c_txre), .cfg_rx_req_en(c_rxre), .tx_push(tx_push),
    .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .tx_req(tx_req), .rx_req(rx_req), .cfg_err(cfg_err), .sts_wr(sts_wr),
    .sts_clr(sts_clr), .sts_flags(sts_flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wbits();
    return int'(c_dsize) + 1 + (c_ext ? 16 : 0);
  endfunction
  function automatic bit netm();
    return c_net || (c_sm1 != 0);
  endfunction
  function automatic bit eng_on();
    return c_run && !(netm() && c_txm == 0);
  endfunction

  task automatic tick(input logic fs, input logic rb, output logic t, output logic o);
    bit_en = 1; frame_sync = fs; rxd = rb;
    @(negedge clk);
    bit_en = 0; frame_sync = 0;
    t = txd; o = txd_oe;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_tx(input logic [31:0] v);
    tx_push = 1; tx_data = v;
    @(negedge clk);
    tx_push = 0;
    if (txq.size() < 16) txq.push_back(v);
  endtask

  task automatic clear_flags(input logic [2:0] v);
    sts_wr = 1; sts_clr = v;
    @(negedge clk);
    sts_wr = 0; sts_clr = 0;
    exp_flags = exp_flags & ~v;
    @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    chk(sts_flags == exp_flags, req, sts_flags, exp_flags);
  endtask

  task automatic check_reqs(input string req);
    logic et, er;
    @(negedge clk); @(negedge clk);
    et = c_txre && (txq.size() <= 7);
    er = c_rxre && (rxq.size() >= 8);
    chk(tx_req == et, {req, " tx_req"}, tx_req, et);
    chk(rx_req == er, {req, " rx_req"}, rx_req, er);
  endtask

  task automatic drain_rx(input string req);
    while (rxq.size() > 0) begin
      logic [31:0] e;
      e = rxq.pop_front();
      chk(!rx_empty && rx_data == e, req, rx_data, e);
      rx_pop = 1;
      @(negedge clk);
      rx_pop = 0;
    end
    chk(rx_empty == 1'b1, {req, " empty"}, rx_empty, 1);
  endtask

  // abort_at >= 0: stop after that many bits of slot 0
  task automatic run_frame(input int abort_at, input string req);
    int w, ns;
    bit en, nm;
    logic [31:0] word, rxw;
    w = wbits(); ns = int'(c_sm1) + 1; en = eng_on(); nm = netm();
    word = 0; rxw = 0;
    if (en && pend_mid) exp_flags[2] = 1'b1;   // R10 frame start cut a slot
    if (en) pend_mid = 0;
    for (int s = 0; s < ns; s++) begin
      for (int b = 0; b < w; b++) begin
        logic rb, t, o, et, eo;
        bit ts, rs;
        rb = 1'($urandom);
        ts = nm ? c_txm[s] : 1'b1;
        rs = nm ? c_rxm[s] : 1'b1;
        if (en && b == 0 && ts) begin
          if (txq.size() > 0) word = txq.pop_front();
          else begin word = 0; exp_flags[1] = 1'b1; end
        end
        et = (en && ts) ? word[w-1-b] : 1'b0;
        eo = en ? (ts || !c_tri) : !c_tri;
        tick(s == 0 && b == 0, rb, t, o);
        chk(t == et && o == eo, req, {t, o}, {et, eo});
        if (en && rs) begin
          rxw = (b == 0) ? 32'(rb) : {rxw[30:0], rb};
          if (b == w - 1) begin
            if (rxq.size() == 16) exp_flags[0] = 1'b1;
            else rxq.push_back(rxw);
          end
        end
        if (abort_at >= 0 && s == 0 && b + 1 == abort_at) begin
          pend_mid = en && (abort_at < w);
          return;
        end
      end
    end
  endtask

  task automatic set_cfg(input logic run, input logic net, input logic [2:0] sm1,
                         input logic [3:0] ds, input logic ext, input logic [7:0] tm,
                         input logic [7:0] rm, input logic tri_en);
    c_run = run; c_net = net; c_sm1 = sm1; c_dsize = ds; c_ext = ext;
    c_txm = tm; c_rxm = rm; c_tri = tri_en;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk(txd == 0 && txd_oe == 0, "reset txd", {txd, txd_oe}, 0);
    chk(sts_flags == 0 && cfg_err == 0, "R11 reset flags", {cfg_err, sts_flags}, 0);
    chk(rx_empty == 1 && tx_req == 0 && rx_req == 0, "R7 reset reqs",
        {rx_empty, tx_req, rx_req}, 3'b100);

    // R3 plain mode: one slot, masks zero, both directions active
    set_cfg(1, 0, 0, 4'd15, 0, 8'h00, 8'h00, 0);
    push_tx(32'hA5C3_1234);
    run_frame(-1, "R2 R3 plain mode");
    drain_rx("R6 plain mode rx");
    check_flags("R3 plain flags");

    // R4 network mode with empty transmit mask
    set_cfg(1, 1, 0, 4'd7, 0, 8'h00, 8'h01, 1);
    @(negedge clk);
    chk(cfg_err == 1, "R4 cfg_err", cfg_err, 1);
    push_tx(32'h0000_00FF);
    run_frame(-1, "R4 R5 blocked frame");
    drain_rx("R4 no rx word");
    chk(txq.size() == 1, "R4 tx untouched", txq.size(), 1);
    set_cfg(1, 1, 0, 4'd7, 0, 8'h01, 8'h00, 1);
    @(negedge clk);
    chk(cfg_err == 0, "R4 cfg_err clears", cfg_err, 0);
    run_frame(-1, "R4 pending word sent");

    // R5 floating in unused slots, four slots of 5 bits
    set_cfg(1, 1, 3'd3, 4'd4, 0, 8'b0101, 8'b1010, 1);
    push_tx(32'h15); push_tx(32'h0A);
    run_frame(-1, "R5 R3 tristate slots");
    drain_rx("R6 masked rx");

    // R9 underrun then R11 clear
    set_cfg(1, 0, 0, 4'd7, 0, 8'h00, 8'h00, 0);
    run_frame(-1, "R9 underrun zeros");
    drain_rx("R9 rx");
    check_flags("R9 underrun flag");
    clear_flags(3'b010);
    check_flags("R11 w1c underrun");

    // R10 frame start inside a slot
    set_cfg(1, 1, 3'd1, 4'd7, 0, 8'b11, 8'b11, 0);
    push_tx(32'h3C); push_tx(32'h81); push_tx(32'h7E);
    run_frame(3, "R10 aborted frame");
    run_frame(-1, "R10 restarted frame");
    drain_rx("R10 only whole words");
    check_flags("R10 bit-count flag");
    clear_flags(3'b001);
    check_flags("R11 clear of clear flag has no effect");
    clear_flags(3'b100);
    check_flags("R11 w1c bitcount");

    // R7 transmit threshold
    c_txre = 1; c_rxre = 1;
    check_reqs("R7 empty");
    for (int i = 0; i < 7; i++) push_tx($urandom);
    check_reqs("R7 seven words");
    push_tx($urandom);
    check_reqs("R7 eight words");
    set_cfg(1, 1, 3'd7, 4'd3, 0, 8'hFF, 8'h00, 0);
    run_frame(-1, "R1 eight slots");
    check_reqs("R7 drained tx");

    // R8 overrun: eight 4-bit receive slots per frame
    set_cfg(1, 1, 3'd7, 4'd3, 0, 8'h01, 8'hFF, 0);
    for (int f = 0; f < 3; f++) begin
      push_tx($urandom);
      run_frame(-1, "R8 fill frame");
      check_reqs("R7 R8 fill level");
      check_flags("R8 overrun flag");
    end
    drain_rx("R8 kept words");
    clear_flags(3'b001);
    check_flags("R11 w1c overrun");

    // random configurations
    for (int k = 0; k < 40; k++) begin
      int nsel;
      set_cfg(1, 1'($urandom), 3'($urandom), 4'($urandom), 1'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom));
      c_txre = 1'($urandom); c_rxre = 1'($urandom);
      nsel = 0;
      for (int s = 0; s <= int'(c_sm1); s++) if (!netm() || c_txm[s]) nsel++;
      if (eng_on()) for (int i = 0; i < nsel; i++) push_tx($urandom);
      run_frame(-1, "R1 R2 R3 R5 random frame");
      check_reqs("R7 random");
      drain_rx("R6 random rx");
      check_flags("R11 random flags");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule